// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recent virtual-to-physical page translations. It sits between a CPU-side request port and a page table walker. Each entry holds a virtual page number, a physical page number, a valid flag, a dirty flag and read, write and execute permission bits. Any translation may occupy any entry, and every tag is compared in the same cycle. A request that hits and passes the permission check gets its physical address on the next cycle, and no walk starts.

A request that misses raises a one-cycle walk request and waits. When the walker answers, the block installs the returned translation in a chosen entry and completes the original request with the returned data. Walker faults go back to the requester and install nothing. A store that hits an entry whose dirty flag is clear also takes the walk path, so that the walker can set the dirty bit in memory before the refreshed entry replaces the stale one. The block never writes translation data back to memory.

A write to the page table base register (the `base_wr` pulse) empties the whole block. A separate invalidate command removes the entry that holds a given virtual page. When no entry is free, the least recently used entry is replaced.

Top module: `xlat_cache`

## Requirements
- R1: A request accepted (req_valid high while req_ready is high) that matches a valid entry, passes the permission check and is not a store to a clean entry returns rsp_valid with rsp_paddr = {stored physical page, request offset} and rsp_fault low on the next cycle, with no walk request.
- R2: A request that matches no valid entry raises walk_req_valid for exactly one cycle, on the cycle after acceptance, with walk_req_vpn set to the request's virtual page. The response appears on the cycle after walk_rsp_valid, with rsp_paddr = {walk_rsp_ppn, request offset}. A later request to the same page then hits.
- R3: Permission bits are perm[2] read, perm[1] write and perm[0] execute. req_kind 0 is a load (needs read), 1 a store (needs write), 2 a fetch (needs execute), and 3 is treated as a load. A hit that fails the check answers with rsp_fault high and rsp_paddr zero on the next cycle, and no walk starts. A walked translation that fails the check answers with a fault but is still installed.
- R4: A permitted store that hits an entry with a clear dirty flag starts a walk with walk_req_store high. The walker's result replaces that same entry, so a following store to the page hits.
- R5: A walker response with walk_rsp_fault high is answered with rsp_fault high and rsp_paddr zero, and nothing is installed. A repeat request walks again.
- R6: A base_wr pulse invalidates every entry at the next clock edge, in any state.
- R7: An inv_valid pulse invalidates any entry holding inv_vpn and leaves every other entry resident.
- R8: A fill reuses an entry that already holds the same page. Otherwise it takes the lowest-numbered invalid entry. Otherwise it takes the least recently used entry, where recency is updated by successful hits and by fills.
- R9: If base_wr, or inv_valid with inv_vpn equal to the walked page, arrives in the same cycle as walk_rsp_valid, the translation is not installed, but the response is still delivered.
- R10: After reset, req_ready is high and rsp_valid and walk_req_valid are low. From the accepting edge of a miss until its response, req_ready is low and req_valid is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | VA_W | Virtual address of the request |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| req_ready | output | 1 | High when a request can be accepted |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | PA_W | Physical address (zero on fault) |
| rsp_fault | output | 1 | Protection or walker fault |
| walk_req_valid | output | 1 | One-cycle walk request strobe |
| walk_req_vpn | output | VA_W-OFS_W | Virtual page to walk |
| walk_req_store | output | 1 | Walk was caused by a store |
| walk_rsp_valid | input | 1 | Walker result strobe |
| walk_rsp_ppn | input | PA_W-OFS_W | Physical page from walker |
| walk_rsp_perm | input | 3 | Read, write, execute bits from walker |
| walk_rsp_dirty | input | 1 | Dirty flag from walker |
| walk_rsp_fault | input | 1 | Walker found no valid mapping |
| base_wr | input | 1 | Page table base register written: empty all entries |
| inv_valid | input | 1 | Invalidate-one command |
| inv_vpn | input | VA_W-OFS_W | Virtual page to invalidate |

## Verification
A valid bit that survives a flush or an invalidate shows up as a hit with no walk pulse on the first request to that page, on the cycle after acceptance. An entry that should be resident but was dropped or evicted by a wrong recency order shows up as an unexpected walk pulse in that same cycle. A wrong physical page, wrong permission bits or a stale dirty flag show up on the response one cycle after a hit, or as a store that walks when it should not. The bench's reference model follows entry contents and recency order on every clock, so any of these divergences is reported on the first cycle in which it reaches a port.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic {ST_IDLE, ST_WALK} xlat_state_e;

  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  // perm = {read, write, execute}
  function automatic logic kind_allowed(input logic [1:0] kind, input logic [2:0] perm);
    case (kind)
      KIND_STORE: kind_allowed = perm[1];
      KIND_FETCH: kind_allowed = perm[0];
      default:    kind_allowed = perm[2];
    endcase
  endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N = 64,
  parameter int W = 20
) (
  input  logic [W-1:0]        key,
  input  logic [N-1:0][W-1:0] tags,
  input  logic [N-1:0]        valid,
  output logic [N-1:0]        hits
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hits[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int N = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  input  logic [N-1:0]  valid,
  output logic [IW-1:0] victim
);
  logic [N-1:0][IW-1:0] age_q;
  logic [N-1:0]         oldest;
  logic                 free_found;

  for (genvar g = 0; g < N; g++) begin : g_age
    assign oldest[g] = (age_q[g] == IW'(N - 1));
    always_ff @(posedge clk) begin
      if (rst)
        age_q[g] <= IW'(g);
      else if (touch) begin
        if (IW'(g) == touch_idx)
          age_q[g] <= '0;
        else if (age_q[g] < age_q[touch_idx])
          age_q[g] <= age_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    victim     = '0;
    free_found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!free_found && !valid[i]) begin
        victim     = IW'(i);
        free_found = 1'b1;
      end
    end
    if (!free_found)
      for (int i = 0; i < N; i++)
        if (oldest[i]) victim = IW'(i);
  end

  // ages stay a permutation, so exactly one entry is the oldest
  p_one_oldest_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest) == 1);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFS_W   = 12,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PPN_W  = PA_W - OFS_W,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic             walk_req_valid,
  output logic [VPN_W-1:0] walk_req_vpn,
  output logic             walk_req_store,
  input  logic             walk_rsp_valid,
  input  logic [PPN_W-1:0] walk_rsp_ppn,
  input  logic [2:0]       walk_rsp_perm,
  input  logic             walk_rsp_dirty,
  input  logic             walk_rsp_fault,
  input  logic             base_wr,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn
);
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0][2:0]       perm_q;
  logic [ENTRIES-1:0]            dirty_q;
  logic [ENTRIES-1:0]            valid_q;

  xlat_state_e     state_q;
  logic [VA_W-1:0] hold_va_q;
  logic [1:0]      hold_kind_q;

  logic [VPN_W-1:0]   lk_vpn, hold_vpn;
  logic [ENTRIES-1:0] lk_hits, inv_hits;
  logic [IW-1:0]      lk_idx, victim, fill_idx, touch_idx;
  logic lk_hit, accept, perm_ok, serve, deny, go_walk, wdone, fill_en, touch;

  assign hold_vpn  = hold_va_q[VA_W-1:OFS_W];
  assign lk_vpn    = (state_q == ST_IDLE) ? req_vaddr[VA_W-1:OFS_W] : hold_vpn;
  assign req_ready = (state_q == ST_IDLE);

  xlat_match #(.N(ENTRIES), .W(VPN_W)) u_lookup (
    .key(lk_vpn), .tags(tag_q), .valid(valid_q), .hits(lk_hits));
  xlat_match #(.N(ENTRIES), .W(VPN_W)) u_inval (
    .key(inv_vpn), .tags(tag_q), .valid(valid_q), .hits(inv_hits));

  always_comb begin
    lk_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_hits[i]) lk_idx = lk_idx | IW'(i);
  end

  assign lk_hit  = |lk_hits;
  assign accept  = req_valid && (state_q == ST_IDLE);
  assign perm_ok = kind_allowed(req_kind, perm_q[lk_idx]);
  assign serve   = accept && lk_hit && perm_ok &&
                   !(req_kind == KIND_STORE && !dirty_q[lk_idx]);
  assign deny    = accept && lk_hit && !perm_ok;
  assign go_walk = accept && !serve && !deny;
  assign wdone   = (state_q == ST_WALK) && walk_rsp_valid;
  assign fill_en = wdone && !walk_rsp_fault && !base_wr &&
                   !(inv_valid && inv_vpn == hold_vpn);
  assign fill_idx  = lk_hit ? lk_idx : victim;
  assign touch     = serve || fill_en;
  assign touch_idx = serve ? lk_idx : fill_idx;

  xlat_lru #(.N(ENTRIES)) u_lru (
    .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx),
    .valid(valid_q), .victim(victim));

  // valid flags: flush beats invalidate beats fill
  always_ff @(posedge clk) begin
    if (rst || base_wr)
      valid_q <= '0;
    else begin
      valid_q <= valid_q & ~(inv_valid ? inv_hits : '0);
      if (fill_en) valid_q[fill_idx] <= 1'b1;
    end
  end

  // entry payload: written only on fill, no reset needed
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]   <= hold_vpn;
      ppn_q[fill_idx]   <= walk_rsp_ppn;
      perm_q[fill_idx]  <= walk_rsp_perm;
      dirty_q[fill_idx] <= walk_rsp_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      hold_va_q      <= '0;
      hold_kind_q    <= '0;
      rsp_valid      <= 1'b0;
      rsp_paddr      <= '0;
      rsp_fault      <= 1'b0;
      walk_req_valid <= 1'b0;
      walk_req_vpn   <= '0;
      walk_req_store <= 1'b0;
    end else begin
      rsp_valid      <= serve || deny || wdone;
      walk_req_valid <= go_walk;
      rsp_fault      <= 1'b0;
      if (serve)
        rsp_paddr <= {ppn_q[lk_idx], req_vaddr[OFS_W-1:0]};
      else if (deny) begin
        rsp_paddr <= '0;
        rsp_fault <= 1'b1;
      end else if (wdone) begin
        if (walk_rsp_fault || !kind_allowed(hold_kind_q, walk_rsp_perm)) begin
          rsp_paddr <= '0;
          rsp_fault <= 1'b1;
        end else
          rsp_paddr <= {walk_rsp_ppn, hold_va_q[OFS_W-1:0]};
      end
      if (go_walk) begin
        state_q        <= ST_WALK;
        hold_va_q      <= req_vaddr;
        hold_kind_q    <= req_kind;
        walk_req_vpn   <= req_vaddr[VA_W-1:OFS_W];
        walk_req_store <= (req_kind == KIND_STORE);
      end else if (wdone)
        state_q <= ST_IDLE;
    end
  end

  p_walk_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    walk_req_valid |=> !walk_req_valid);
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && walk_req_valid));
  p_fault_qualified_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_valid);
  p_flush_empties_r6: assert property (@(posedge clk) disable iff (rst)
    base_wr |=> (valid_q == '0));
  p_unique_page_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hits));
  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
    walk_req_valid |-> !req_ready);
endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  localparam int NE = 4;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_ready, rsp_valid, rsp_fault, walk_req_valid, walk_req_store;
  logic [31:0] rsp_paddr;
  logic [19:0] walk_req_vpn;
  logic        walk_rsp_valid = 1'b0;
  logic [19:0] walk_rsp_ppn = '0;
  logic [2:0]  walk_rsp_perm = '0;
  logic        walk_rsp_dirty = 1'b0;
  logic        walk_rsp_fault = 1'b0;
  logic        tb_flush = 1'b0, wk_flush = 1'b0, tb_inv = 1'b0, wk_inv = 1'b0;
  logic [19:0] tb_inv_vpn = '0, wk_inv_vpn = '0;
  logic        base_wr, inv_valid;
  logic [19:0] inv_vpn;
  assign base_wr   = tb_flush | wk_flush;
  assign inv_valid = tb_inv | wk_inv;
  assign inv_vpn   = wk_inv ? wk_inv_vpn : tb_inv_vpn;

  xlat_cache #(.ENTRIES(NE)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .walk_req_valid(walk_req_valid),
    .walk_req_vpn(walk_req_vpn), .walk_req_store(walk_req_store),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ppn(walk_rsp_ppn),
    .walk_rsp_perm(walk_rsp_perm), .walk_rsp_dirty(walk_rsp_dirty),
    .walk_rsp_fault(walk_rsp_fault), .base_wr(base_wr), .inv_valid(inv_valid),
    .inv_vpn(inv_vpn));

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R10";
  bit started = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // page table seen by the walker
  function automatic logic [19:0] pt_ppn(input logic [19:0] v); return v ^ 20'h3C0F0; endfunction
  function automatic logic [2:0] pt_perm(input logic [19:0] v); return {1'b1, v[4], v[5]}; endfunction
  function automatic bit pt_fault(input logic [19:0] v); return v[11:8] == 4'hF; endfunction
  function automatic bit kind_ok(input logic [1:0] k, input logic [2:0] p);
    if (k == 2'd1) return p[1];
    if (k == 2'd2) return p[0];
    return p[2];
  endfunction

  // walker: answers LAT negedges after seeing a request
  int wk_cnt = 0;
  logic [19:0] wk_vpn;
  logic wk_st;
  bit wk_flush_on = 0, wk_inv_on = 0;
  logic [19:0] wk_inv_sel = '0;
  always @(negedge clk) begin
    walk_rsp_valid = 1'b0; wk_flush = 1'b0; wk_inv = 1'b0;
    if (wk_cnt == 1) begin
      walk_rsp_valid = 1'b1;
      walk_rsp_ppn   = pt_ppn(wk_vpn);
      walk_rsp_perm  = pt_perm(wk_vpn);
      walk_rsp_dirty = wk_st | wk_vpn[6];
      walk_rsp_fault = pt_fault(wk_vpn);
      wk_flush       = wk_flush_on;
      wk_inv         = wk_inv_on;
      wk_inv_vpn     = wk_inv_sel;
      wk_cnt = 0;
    end else if (wk_cnt > 1) wk_cnt--;
    if (walk_req_valid) begin
      wk_cnt = LAT; wk_vpn = walk_req_vpn; wk_st = walk_req_store;
    end
  end

  // behavioural reference model
  logic [19:0] m_vpn [NE];
  logic [19:0] m_ppn [NE];
  logic [2:0]  m_perm [NE];
  bit          m_dirty [NE];
  bit          m_val [NE];
  int          order[$];
  bit m_busy, m_rv, m_rf, m_wv, m_wst;
  logic [31:0] m_rpa, m_hva;
  logic [19:0] m_wvpn;
  logic [1:0]  m_hk;

  function automatic int m_find(input logic [19:0] v);
    for (int i = 0; i < NE; i++) if (m_val[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction
  function automatic int m_victim();
    for (int i = 0; i < NE; i++) if (!m_val[i]) return i;
    return order[order.size()-1];
  endfunction
  task automatic m_touch(input int k);
    for (int i = 0; i < order.size(); i++)
      if (order[i] == k) begin order.delete(i); break; end
    order.push_front(k);
  endtask

  always @(posedge clk) begin : model
    int hi, slot;
    bit fill;
    logic [19:0] kv;
    if (rst) begin
      order.delete();
      for (int i = 0; i < NE; i++) begin order.push_back(i); m_val[i] = 0; end
      m_busy = 0; m_rv = 0; m_rf = 0; m_wv = 0; m_wst = 0;
      m_rpa = '0; m_hva = '0; m_hk = '0; m_wvpn = '0;
    end else begin
      fill = 0; slot = 0;
      kv = m_busy ? m_hva[31:12] : req_vaddr[31:12];
      hi = m_find(kv);
      m_rv = 0; m_rf = 0; m_wv = 0;
      if (!m_busy && req_valid) begin
        if (hi >= 0 && kind_ok(req_kind, m_perm[hi]) && !(req_kind == 2'd1 && !m_dirty[hi])) begin
          m_rv = 1; m_rpa = {m_ppn[hi], req_vaddr[11:0]}; m_touch(hi);
        end else if (hi >= 0 && !kind_ok(req_kind, m_perm[hi])) begin
          m_rv = 1; m_rf = 1; m_rpa = '0;
        end else begin
          m_busy = 1; m_hva = req_vaddr; m_hk = req_kind;
          m_wv = 1; m_wvpn = req_vaddr[31:12]; m_wst = (req_kind == 2'd1);
        end
      end else if (m_busy && walk_rsp_valid) begin
        m_busy = 0; m_rv = 1;
        if (walk_rsp_fault) begin m_rf = 1; m_rpa = '0; end
        else begin
          m_rf  = !kind_ok(m_hk, walk_rsp_perm);
          m_rpa = m_rf ? 32'h0 : {walk_rsp_ppn, m_hva[11:0]};
          if (!base_wr && !(inv_valid && inv_vpn == m_hva[31:12])) begin
            fill = 1; slot = (hi >= 0) ? hi : m_victim();
          end
        end
      end
      if (base_wr) for (int i = 0; i < NE; i++) m_val[i] = 0;
      else begin
        if (inv_valid) for (int i = 0; i < NE; i++)
          if (m_val[i] && m_vpn[i] == inv_vpn) m_val[i] = 0;
        if (fill) begin
          m_val[slot] = 1; m_vpn[slot] = m_hva[31:12]; m_ppn[slot] = walk_rsp_ppn;
          m_perm[slot] = walk_rsp_perm; m_dirty[slot] = walk_rsp_dirty;
          m_touch(slot);
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (!rst && started) begin
    chk(req_ready == !m_busy, cur_req, "req_ready", req_ready, !m_busy);
    chk(rsp_valid == m_rv, cur_req, "rsp_valid", rsp_valid, m_rv);
    if (m_rv) begin
      chk(rsp_paddr == m_rpa, cur_req, "rsp_paddr", rsp_paddr, m_rpa);
      chk(rsp_fault == m_rf, cur_req, "rsp_fault", rsp_fault, m_rf);
    end
    chk(walk_req_valid == m_wv, cur_req, "walk_req_valid", walk_req_valid, m_wv);
    if (m_wv) begin
      chk(walk_req_vpn == m_wvpn, cur_req, "walk_req_vpn", walk_req_vpn, m_wvpn);
      chk(walk_req_store == m_wst, cur_req, "walk_req_store", walk_req_store, m_wst);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++; total++;
      $display("FAIL R10 watchdog actual=%0d expected=<50000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // one request from idle, with independent expectations
  task automatic access(input logic [19:0] vpn, input logic [11:0] off, input logic [1:0] kind,
                        input bit exp_walk, input bit junk, input string tag);
    int waited, walks;
    bit got, wstore, ef;
    logic [31:0] ep;
    cur_req = tag;
    ef = exp_walk ? (pt_fault(vpn) || !kind_ok(kind, pt_perm(vpn)))
                  : !kind_ok(kind, pt_perm(vpn));
    ep = ef ? 32'h0 : {pt_ppn(vpn), off};
    req_vaddr = {vpn, off}; req_kind = kind; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0; walks = 0; got = 0; wstore = 0;
    while (!got && waited < 40) begin
      if (walk_req_valid) begin walks++; wstore = walk_req_store; end
      if (rsp_valid) got = 1;
      else begin
        if (junk) begin
          chk(req_ready == 1'b0, "R10", "ready while walking", req_ready, 0);
          req_valid = 1'b1; req_vaddr = {20'h1E0, 12'h0}; req_kind = 2'd0;
        end
        @(negedge clk); waited++;
      end
    end
    req_valid = 1'b0;
    chk(got, tag, "response seen", got, 1);
    chk(rsp_paddr == ep, tag, "paddr", rsp_paddr, ep);
    chk(rsp_fault == ef, tag, "fault", rsp_fault, ef);
    chk(walks == (exp_walk ? 1 : 0), tag, "walk count", walks, exp_walk ? 1 : 0);
    chk(waited == (exp_walk ? LAT + 1 : 0), tag, "latency", waited, exp_walk ? LAT + 1 : 0);
    if (exp_walk) chk(wstore == (kind == 2'd1), tag, "walk store flag", wstore, kind == 2'd1);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    started = 1;
    chk(req_ready == 1'b1, "R10", "reset ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R10", "reset rsp", rsp_valid, 0);
    chk(walk_req_valid == 1'b0, "R10", "reset walk", walk_req_valid, 0);

    access(20'h010, 12'h123, 2'd0, 1, 0, "R2");
    access(20'h010, 12'h456, 2'd0, 0, 0, "R1");
    access(20'h020, 12'h001, 2'd0, 1, 0, "R8");
    access(20'h030, 12'h002, 2'd0, 1, 0, "R8");
    access(20'h040, 12'h003, 2'd0, 1, 0, "R8");
    access(20'h010, 12'h004, 2'd0, 0, 0, "R1");
    access(20'h080, 12'h005, 2'd0, 1, 0, "R8");  // evicts 0x020
    access(20'h030, 12'h006, 2'd0, 0, 0, "R8");
    access(20'h020, 12'h007, 2'd0, 1, 0, "R8");  // evicts 0x040

    access(20'h010, 12'h0AA, 2'd1, 1, 0, "R4");  // clean store walks
    access(20'h010, 12'h0BB, 2'd1, 0, 0, "R4");

    access(20'h010, 12'h011, 2'd2, 0, 0, "R3");  // no execute
    access(20'h080, 12'h012, 2'd1, 0, 0, "R3");  // no write
    access(20'h020, 12'h013, 2'd2, 0, 0, "R3");  // execute allowed
    access(20'h030, 12'h014, 2'd3, 0, 0, "R3");  // kind 3 as load
    access(20'h0A0, 12'h015, 2'd1, 1, 0, "R3");  // walked, no write
    access(20'h0A0, 12'h016, 2'd0, 0, 0, "R3");  // still installed

    access(20'hF00, 12'h020, 2'd0, 1, 0, "R5");
    access(20'hF00, 12'h021, 2'd0, 1, 0, "R5");

    cur_req = "R7";
    tb_inv = 1'b1; tb_inv_vpn = 20'h030; @(negedge clk); tb_inv = 1'b0;
    access(20'h030, 12'h030, 2'd0, 1, 0, "R7");
    cur_req = "R7";
    tb_inv = 1'b1; tb_inv_vpn = 20'h777; @(negedge clk); tb_inv = 1'b0;
    access(20'h030, 12'h031, 2'd0, 0, 0, "R7");

    cur_req = "R6";
    tb_flush = 1'b1; @(negedge clk); tb_flush = 1'b0;
    access(20'h030, 12'h040, 2'd0, 1, 0, "R6");
    access(20'h010, 12'h041, 2'd0, 1, 0, "R6");

    wk_flush_on = 1;
    access(20'h0B0, 12'h050, 2'd0, 1, 0, "R9");
    wk_flush_on = 0;
    access(20'h0B0, 12'h051, 2'd0, 1, 0, "R9");
    wk_inv_on = 1; wk_inv_sel = 20'h0C0;
    access(20'h0C0, 12'h052, 2'd0, 1, 0, "R9");
    wk_inv_sel = 20'h999;
    access(20'h0D0, 12'h053, 2'd0, 1, 0, "R9");
    wk_inv_on = 0;
    access(20'h0C0, 12'h054, 2'd0, 1, 0, "R9");
    access(20'h0D0, 12'h055, 2'd0, 0, 0, "R9");

    access(20'h0F0, 12'h060, 2'd0, 1, 1, "R10");
    access(20'h0F0, 12'h061, 2'd0, 0, 0, "R10");
    access(20'h1E0, 12'h062, 2'd0, 1, 0, "R10");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule